// File: doc/BRIEF.md
# Transmit skew buffer

This block sits at the transmit data input of one serial channel. It carries each character into the local reference clock domain. A character is 10 bits: eight data bits plus control, or one raw character. A mode input chooses where the character is captured. It can be captured on the reference clock itself, on a clock shared by every channel, or on the channel's own input clock. The capture clock must run at the reference frequency, but its phase is unknown and may wander.

When a separate input clock is in use, characters pass through a small elastic store. Reset recentres the store. A bounded amount of wander is absorbed without effect. When the wander goes past what the store can hold, the block gives up one character: it repeats one if the input falls behind, or skips one if the input runs ahead. Either event raises an error flag, which holds until the next reset. When the reference clock is the capture source, the store is bypassed and the flag stays low.

Top module: `txsk_skewbuf`

## Requirements
- R1: With mode 000 the input is registered on the reference clock, so dout_o equals the din_i value present at the previous reference rising edge.
- R2: Modes 001, 010 and 011 are reserved and behave exactly like mode 000.
- R3: In modes 000, 001, 010 and 011, err_o stays low even when neither input clock toggles.
- R4: In modes with bit 2 set, bit 0 picks the capture clock: 0 (modes 100, 110) selects shared_clk and 1 (modes 101, 111) selects own_clk. The unselected clock has no effect.
- R5: In modes with bit 2 set, a stream of characters captured once per input clock period appears on dout_o one per reference period, in order, with nothing lost or repeated.
- R6: While rst_n is low, dout_o is 0 and err_o is 0. Releasing reset recentres the store, with the reader starting two entries behind the writer.
- R7: If the input clock falls far enough behind that the next character is not yet written, the previous character is repeated on dout_o and err_o rises.
- R8: If the input clock gets far enough ahead that an unread character is overwritten, one or more characters are skipped on dout_o and err_o rises.
- R9: Once high, err_o stays high until rst_n is asserted.
- R10: After a repeat or a skip, in-order delivery with a step of one per reference period resumes without a reset.
- R11: A phase shift of half a character period after recentring causes no repeat, no skip and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Local reference clock; output domain |
| rst_n | input | 1 | Asynchronous active-low reset; recentres the store |
| mode_i | input | 3 | Capture source select (static) |
| shared_clk | input | 1 | Capture clock shared by all channels |
| own_clk | input | 1 | This channel's own capture clock |
| din_i | input | DATA_W | Character to transmit |
| dout_o | output | DATA_W | Character in the reference domain |
| err_o | output | 1 | Sticky repeat/skip indicator |

## Verification
The bench uses the default DATA_W of 10 and DEPTH of 4. Each drift scenario therefore runs through the whole lap-tag range within a few dozen cycles, and both the overwrite limit and the not-yet-written limit can be reached with lags or bursts of only a few character periods. The input clock is delayed by half a period, delayed by four periods, and given five extra edges. A further case stops the selected clock while the other one keeps running. Together these reach the repeat, skip, recovery and clock-selection behaviour.

// File: rtl/txsk_pkg.sv
package txsk_pkg;

  // Reader verdict for the entry it is about to consume
  typedef enum logic [1:0] {
    RD_OK    = 2'd0,
    RD_UNDER = 2'd1,
    RD_OVER  = 2'd2
  } rd_state_e;

  // Bit 2 clear: capture on the reference clock (000 plus reserved codes)
  function automatic logic mode_is_bypass(input logic [2:0] m);
    return ~m[2];
  endfunction

  // Bit 0 set: the channel's own clock, otherwise the shared clock
  function automatic logic mode_own_clk(input logic [2:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/txsk_rst_sync.sv
module txsk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/txsk_wr.sv
module txsk_wr #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LAP_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [DATA_W-1:0]               din,
  output logic [DEPTH-1:0][DATA_W-1:0]    mem_data,
  output logic [DEPTH-1:0][LAP_W-1:0]     mem_tag
);

  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned CW     = AW + LAP_W;
  localparam int unsigned OFFSET = DEPTH / 2;

  logic [CW-1:0] wcnt_q;
  logic [CW-1:0] wcnt_d;
  logic [AW-1:0] waddr;
  logic [LAP_W-1:0] wlap;

  always_comb begin
    waddr  = wcnt_q[AW-1:0];
    wlap   = wcnt_q[CW-1:AW];
    wcnt_d = wcnt_q;
    if (wr_en) begin
      wcnt_d = wcnt_q + CW'(1);
    end
  end

  // Writer starts OFFSET entries ahead of the reader
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= CW'(OFFSET);
    end else begin
      wcnt_q <= wcnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    // Entries below OFFSET count as filled in lap 0, the rest as a lap behind
    localparam logic [LAP_W-1:0] TAG_RST = {LAP_W{(i >= OFFSET)}};
    logic              hit;
    logic [DATA_W-1:0] data_q;
    logic [LAP_W-1:0]  tag_q;

    assign hit = wr_en && (waddr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        tag_q  <= TAG_RST;
      end else if (hit) begin
        data_q <= din;
        tag_q  <= wlap;
      end
    end

    assign mem_data[i] = data_q;
    assign mem_tag[i]  = tag_q;
  end

  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_tag[$past(waddr)] == $past(wlap))) else $error("write lost"); // R5

endmodule

// File: rtl/txsk_rd.sv
module txsk_rd
  import txsk_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LAP_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DEPTH-1:0][DATA_W-1:0]    mem_data,
  input  logic [DEPTH-1:0][LAP_W-1:0]     mem_tag,
  output logic [DATA_W-1:0]               dout,
  output logic                            err
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + LAP_W;

  logic [CW-1:0]     rcnt_q, rcnt_d;
  logic [DATA_W-1:0] dout_q, dout_d;
  logic              err_q, err_d;
  logic [AW-1:0]     a0, a1;
  logic [LAP_W-1:0]  lap_diff;
  rd_state_e         st;

  always_comb begin
    a0       = rcnt_q[AW-1:0];
    a1       = a0 + AW'(1);
    lap_diff = mem_tag[a0] - rcnt_q[CW-1:AW];
    if (lap_diff == '0) begin
      st = RD_OK;
    end else if (lap_diff == LAP_W'(1)) begin
      st = RD_OVER;
    end else begin
      st = RD_UNDER;
    end

    rcnt_d = rcnt_q;
    dout_d = dout_q;
    unique case (st)
      RD_OK: begin
        dout_d = mem_data[a0];
        rcnt_d = rcnt_q + CW'(1);
      end
      RD_OVER: begin
        // wanted entry is gone: take its successor and step past both
        dout_d = mem_data[a1];
        rcnt_d = rcnt_q + CW'(2);
      end
      default: begin
        // not yet written: hold output and pointer
      end
    endcase
    err_d = err_q | (st != RD_OK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      dout_q <= '0;
      err_q  <= 1'b0;
    end else begin
      rcnt_q <= rcnt_d;
      dout_q <= dout_d;
      err_q  <= err_d;
    end
  end

  assign dout = dout_q;
  assign err  = err_q;

  AST_SLIP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (st != RD_OK) |=> err) else $error("slip without flag"); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err) else $error("flag dropped"); // R9
  AST_UNDER_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RD_UNDER) |=> $stable(dout)) else $error("no repeat"); // R7

endmodule

// File: rtl/txsk_skewbuf.sv
module txsk_skewbuf
  import txsk_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_i,
  input  logic              shared_clk,
  input  logic              own_clk,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              err_o
);

  localparam int unsigned LAP_W = 2;

  logic bypass;
  logic wclk;
  logic rrst_n;
  logic wrst_n;
  logic [DEPTH-1:0][DATA_W-1:0] mem_data;
  logic [DEPTH-1:0][LAP_W-1:0]  mem_tag;
  logic [DATA_W-1:0] fifo_dout;
  logic              fifo_err;
  logic [DATA_W-1:0] byp_q, byp_d;

  assign bypass = mode_is_bypass(mode_i);
  assign wclk   = mode_own_clk(mode_i) ? own_clk : shared_clk;

  txsk_rst_sync u_rsync (.clk(ref_clk), .arst_n(rst_n), .srst_n(rrst_n));
  txsk_rst_sync u_wsync (.clk(wclk),    .arst_n(rst_n), .srst_n(wrst_n));

  txsk_wr #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LAP_W(LAP_W)) u_wr (
    .clk      (wclk),
    .rst_n    (wrst_n),
    .wr_en    (~bypass),
    .din      (din_i),
    .mem_data (mem_data),
    .mem_tag  (mem_tag)
  );

  txsk_rd #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LAP_W(LAP_W)) u_rd (
    .clk      (ref_clk),
    .rst_n    (rrst_n),
    .mem_data (mem_data),
    .mem_tag  (mem_tag),
    .dout     (fifo_dout),
    .err      (fifo_err)
  );

  // Bypass capture register on the reference clock
  always_comb begin
    byp_d = byp_q;
    if (bypass) begin
      byp_d = din_i;
    end
  end

  always_ff @(posedge ref_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      byp_q <= '0;
    end else begin
      byp_q <= byp_d;
    end
  end

  assign dout_o = bypass ? byp_q : fifo_dout;
  assign err_o  = fifo_err & ~bypass;

  AST_BYPASS_FOLLOWS: assert property (@(posedge ref_clk) disable iff (!rrst_n)
    ($past(rrst_n) && bypass && $past(bypass)) |-> (dout_o == $past(din_i)))
    else $error("bypass mismatch"); // R1

endmodule

// File: tb/txsk_skewbuf_bench.sv
module txsk_skewbuf_bench;

  localparam int CLK_PERIOD = 20;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int DW         = 10;
  localparam int NROWS      = 9;

  // row layout: [7:5] mode, [4] run shared, [3] run own, [2:1] kind, [0] bypass
  // kind: 0 clean, 1 lag of 4 periods, 2 burst of 5 extra edges, 3 dead clock
  localparam logic [7:0] TABLE [NROWS] = '{
    8'b000_0_0_00_1,
    8'b010_0_0_00_1,
    8'b001_0_0_00_1,
    8'b100_1_0_00_0,
    8'b101_0_1_00_0,
    8'b111_0_1_00_0,
    8'b110_1_0_01_0,
    8'b101_0_1_10_0,
    8'b100_0_1_11_0
  };

  logic          ref_clk, src, rst_n;
  logic [2:0]    mode;
  logic          run_a, run_n, manual;
  logic [DW-1:0] auto_din, man_din, din, dout;
  logic          err;
  logic          shared_clk, own_clk;
  int            lag_req, burst_req, half_lag;
  int            checks, failures;

  assign shared_clk = src & run_a;
  assign own_clk    = src & run_n;
  assign din        = manual ? man_din : auto_din;

  txsk_skewbuf u_txsk_skewbuf (
    .ref_clk(ref_clk), .rst_n(rst_n), .mode_i(mode),
    .shared_clk(shared_clk), .own_clk(own_clk),
    .din_i(din), .dout_o(dout), .err_o(err)
  );

  initial begin
    ref_clk = 1'b0;
    #(HALF / 2);
    forever #(HALF) ref_clk = ~ref_clk;
  end

  initial begin
    src = 1'b0;
    forever begin
      #(HALF) src = 1'b1;
      #(HALF) src = 1'b0;
      if (lag_req > 0) begin
        #(lag_req);
        lag_req = 0;
      end
      while (burst_req > 0) begin
        #2 src = 1'b1;
        #2 src = 1'b0;
        burst_req = burst_req - 1;
      end
    end
  end

  always @(negedge src) auto_din <= auto_din + 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    lag_req = 0; burst_req = 0; half_lag = 0;
    auto_din = '0; man_din = '0; manual = 1'b0;
    rst_n = 1'b0; mode = 3'b000; run_a = 1'b0; run_n = 1'b0;

    for (int r = 0; r < NROWS; r++) begin
      logic [7:0] row;
      int kind;
      row = TABLE[r];
      kind = int'(row[2:1]);
      rst_n = 1'b0;
      mode = row[7:5]; run_a = row[4]; run_n = row[3]; manual = row[0];
      repeat (4) @(negedge ref_clk);
      chk(dout == '0, "R6 reset dout", int'(dout), 0);
      chk(err == 1'b0, "R6 reset err", int'(err), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge ref_clk);
      if (row[0]) begin
        logic [DW-1:0] prev;
        prev = man_din;
        for (int i = 0; i < 20; i++) begin
          @(negedge ref_clk);
          if (mode == 3'b000) chk(dout == prev, "R1 bypass", int'(dout), int'(prev));
          else chk(dout == prev, "R2 reserved", int'(dout), int'(prev));
          man_din = DW'(r * 37 + i * 13 + 5);
          prev = man_din;
        end
        chk(err == 1'b0, "R3 no error in bypass", int'(err), 0);
      end else begin
        logic [DW-1:0] prev, cur, step;
        int nonunit, dups, jumps, late_bad;
        nonunit = 0; dups = 0; jumps = 0; late_bad = 0;
        repeat (8) @(negedge ref_clk);
        prev = dout;
        for (int i = 1; i <= 40; i++) begin
          @(negedge ref_clk);
          if (i == 10) begin
            if (kind == 1) lag_req = 4 * CLK_PERIOD;
            if (kind == 2) burst_req = 5;
            if (kind == 0 && r == 5) lag_req = HALF;
          end
          cur = dout;
          step = cur - prev;
          if (step != 1) nonunit++;
          if (step == 0) dups++;
          if (step > 1) jumps++;
          if (i > 32 && step != 1) late_bad++;
          prev = cur;
        end
        case (kind)
          0: begin
            if (r == 5) chk(nonunit == 0, "R11 half-period shift", nonunit, 0);
            else chk(nonunit == 0, "R4 R5 in-order stream", nonunit, 0);
            chk(err == 1'b0, "R5 no error", int'(err), 0);
          end
          1: begin
            chk(err == 1'b1, "R7 lag flags error", int'(err), 1);
            chk(dups > 0, "R7 repeat seen", dups, 1);
            chk(late_bad == 0, "R10 resumes after repeat", late_bad, 0);
          end
          2: begin
            chk(err == 1'b1, "R8 lead flags error", int'(err), 1);
            chk(jumps > 0, "R8 skip seen", jumps, 1);
            chk(late_bad == 0, "R10 resumes after skip", late_bad, 0);
          end
          default: begin
            chk(err == 1'b1, "R4 unselected clock ignored", int'(err), 1);
            chk(dups == 40, "R4 output frozen", dups, 40);
          end
        endcase
      end
    end

    // Directed: sticky flag and recentring by reset
    rst_n = 1'b0; manual = 1'b0; mode = 3'b101; run_a = 1'b0; run_n = 1'b1;
    repeat (4) @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (12) @(negedge ref_clk);
    burst_req = 5;
    repeat (40) @(negedge ref_clk);
    chk(err == 1'b1, "R8 flag after burst", int'(err), 1);
    repeat (40) @(negedge ref_clk);
    chk(err == 1'b1, "R9 flag held", int'(err), 1);
    rst_n = 1'b0;
    repeat (4) @(negedge ref_clk);
    chk(err == 1'b0, "R6 reset clears flag", int'(err), 0);
    chk(dout == '0, "R6 reset clears data", int'(dout), 0);
    rst_n = 1'b1;
    repeat (12) @(negedge ref_clk);
    begin
      logic [DW-1:0] prev, cur;
      int bad;
      bad = 0;
      prev = dout;
      for (int i = 0; i < 30; i++) begin
        @(negedge ref_clk);
        cur = dout;
        if (DW'(cur - prev) != 1) bad++;
        prev = cur;
      end
      chk(bad == 0, "R6 recentred stream", bad, 0);
      chk(err == 1'b0, "R6 no error after recentre", int'(err), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule